// File: doc/BRIEF.md
# Float to Packed BCD Store Unit

This unit turns the top entry of a floating-point register stack into a signed 18-digit packed decimal integer for a memory store. A request carries an 80-bit extended-precision value (sign in bit 79, 15-bit biased exponent in bits 78:64 with bias 16383, 64-bit significand in bits 63:0 with an explicit integer bit in bit 63). It also carries a flag saying the top register is empty, the current stack-top index, a 2-bit rounding control and the invalid-operation mask. The unit classifies the operand, rounds it to an integer, checks that the result fits in 18 decimal digits, and converts the binary magnitude to decimal with a bit-serial shift-and-adjust sequence.

Every accepted request completes after the same number of cycles, whether or not the operand is valid. The completion cycle carries a store strobe with the 80-bit decimal word, the exception flags, the rounding direction bit and a stack pop. An invalid operand either stores the decimal indefinite code or, when the invalid exception is unmasked, suppresses both the store and the pop so that the surrounding pipeline can trap.

Top module: `bcd_store_unit`

## Requirements
- R1: `done_o` is a one-cycle pulse, high exactly 60 clock cycles after the edge that accepts `start_i` (one cycle per bit of the 60-bit magnitude); `start_i` seen while a conversion runs is ignored, and after reset `done_o`, `wr_en_o` and `pop_o` are low.
- R2: For a valid operand `wr_en_o` pulses with `done_o`, and `bcd_o` holds the source sign in bit 79, zeros in bits 78:72, and 18 decimal digits in bits 71:0, four bits per digit, least significant digit in bits 3:0; zero results keep the source sign.
- R3: Rounding to an integer follows `rc_i`: 0 nearest with ties to even, 1 toward minus infinity, 2 toward plus infinity, 3 toward zero.
- R4: `prec_o` is 1 exactly when the operand is valid and its value is not an integer; it is 0 whenever `inv_o` is 1.
- R5: `c1_o` is 1 exactly when rounding increased the magnitude of the result; it is 0 for any invalid or empty operand.
- R6: A rounded magnitude above 999,999,999,999,999,999 sets `inv_o`.
- R7: An operand with exponent field 0x7FFF (infinities and NaNs, whatever the significand) or with a nonzero exponent field and bit 63 clear (unsupported encoding) sets `inv_o`.
- R8: An empty top register (`top_empty_i` = 1) sets `stk_o` and `inv_o` and forces `c1_o` to 0.
- R9: An invalid result with `inv_mask_i` = 1 stores the indefinite code 0xFFFF_C000_0000_0000_0000 on `bcd_o` with `wr_en_o` high.
- R10: An invalid result with `inv_mask_i` = 0 keeps `wr_en_o` and `pop_o` low in the `done_o` cycle.
- R11: In every other case `pop_o` pulses with `done_o`, `free_reg_o` gives the stack-top index of the request (the register to mark empty) and `pop_top_o` gives that index plus one modulo 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| src_i | input | 80 | Extended-precision source value |
| top_empty_i | input | 1 | Top register is empty (stack underflow) |
| top_ptr_i | input | 3 | Current stack-top index |
| rc_i | input | 2 | Rounding control |
| inv_mask_i | input | 1 | Invalid-operation exception masked |
| done_o | output | 1 | Completion pulse |
| wr_en_o | output | 1 | Store strobe for `bcd_o` |
| bcd_o | output | 80 | Signed packed decimal word |
| inv_o | output | 1 | Invalid-operand flag |
| prec_o | output | 1 | Inexact (precision) flag |
| stk_o | output | 1 | Stack-underflow flag |
| c1_o | output | 1 | Result was rounded up in magnitude |
| pop_o | output | 1 | Pop the register stack |
| free_reg_o | output | 3 | Register index to mark empty |
| pop_top_o | output | 3 | New stack-top index after the pop |

## Verification
The assertions take for granted that `start_i` and the request fields are steady across the accepting edge and that the flags are read from the completion pulse until the next accepted request. The bench drives requests only on falling edges and holds the fields until after the accepting edge. Random operands keep their exponent between 2^-3 and 2^61 so that both the in-range and out-of-range paths and every rounding mode are reached; special encodings, empty registers and unmasked invalid cases are added as directed cases.

// File: rtl/bcdst_pkg.sv
package bcdst_pkg;

    localparam int EXT_W    = 80;
    localparam int EXP_W    = 15;
    localparam int MAN_W    = 64;
    localparam int EXP_BIAS = 16383;
    localparam int DIGITS   = 18;

    typedef enum logic [1:0] {
        RC_NEAREST = 2'd0,
        RC_DOWN    = 2'd1,
        RC_UP      = 2'd2,
        RC_ZERO    = 2'd3
    } rc_e;

    // largest magnitude with d decimal digits (all nines)
    function automatic logic [63:0] all_nines(int d);
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < d; i++) r = r * 64'd10 + 64'd9;
        return r;
    endfunction

    // bits needed to hold the largest d-digit magnitude
    function automatic int nines_bits(int d);
        logic [63:0] v;
        int          n;
        v = all_nines(d);
        n = 0;
        while (v != 0) begin
            n++;
            v = v >> 1;
        end
        return n;
    endfunction

endpackage

// File: rtl/bcdst_round.sv
module bcdst_round
    import bcdst_pkg::*;
#(
    parameter int NDIG  = DIGITS,
    parameter int MAG_W = nines_bits(NDIG)
) (
    input  logic [EXT_W-1:0] src_i,
    input  logic [1:0]       rc_i,
    input  logic             empty_i,
    output logic             sign_o,
    output logic [MAG_W-1:0] mag_o,
    output logic             inv_o,
    output logic             prec_o,
    output logic             c1_o,
    output logic             stk_o
);

    localparam logic [63:0]        MAX_MAG = all_nines(NDIG);
    localparam logic signed [17:0] E_LIM   = 18'(MAG_W);
    localparam logic signed [17:0] BIAS    = 18'(EXP_BIAS);

    logic [EXP_W-1:0]   ex;
    logic [MAN_W-1:0]   man;
    logic signed [17:0] e_unb;
    logic               special, too_big, inexact, inc, out_rng;
    logic [6:0]         sh;
    logic [127:0]       ext;
    logic [63:0]        ip, sum;
    logic               rb, st;

    always_comb begin
        ex      = src_i[EXT_W-2 -: EXP_W];
        man     = src_i[MAN_W-1:0];
        e_unb   = $signed({3'b000, ex}) - BIAS;
        special = (ex == '1) || ((ex != '0) && !man[MAN_W-1]);
        too_big = (e_unb >= E_LIM);
        sh      = '0;
        ext     = '0;
        ip      = '0;
        rb      = 1'b0;
        st      = 1'b0;
        if (!too_big && e_unb >= -18'sd1) begin
            sh  = 7'(18'sd63 - e_unb);
            ext = {man, 64'b0} >> sh;
            ip  = ext[127:64];
            rb  = ext[63];
            st  = |ext[62:0];
        end else if (!too_big) begin
            st  = |man;
        end
        inexact = rb | st;
        unique case (rc_e'(rc_i))
            RC_NEAREST: inc = rb & (st | ip[0]);
            RC_DOWN:    inc = src_i[EXT_W-1] & inexact;
            RC_UP:      inc = !src_i[EXT_W-1] & inexact;
            default:    inc = 1'b0;
        endcase
        sum     = ip + 64'(inc);
        out_rng = too_big || (sum > MAX_MAG);
        inv_o   = empty_i | special | out_rng;
        stk_o   = empty_i;
        prec_o  = !inv_o & inexact;
        c1_o    = !inv_o & inc;
        sign_o  = src_i[EXT_W-1];
        mag_o   = inv_o ? '0 : sum[MAG_W-1:0];
    end

endmodule

// File: rtl/bcdst_dabble.sv
module bcdst_dabble #(
    parameter int NDIG  = 18,
    parameter int MAG_W = 60
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [MAG_W-1:0]  bin_i,
    output logic              busy_o,
    output logic              last_o,
    output logic [4*NDIG-1:0] bcd_o
);

    localparam int BCD_W = 4 * NDIG;
    localparam int CNT_W = $clog2(MAG_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [MAG_W-1:0] bin;
        logic [BCD_W-1:0] bcd;
    } dd_t;

    dd_t                    st_d, st_q;
    logic [BCD_W-1:0]       adj;
    logic [BCD_W+MAG_W-1:0] cat;

    always_comb begin
        st_d = st_q;
        adj  = st_q.bcd;
        cat  = '0;
        if (load_i) begin
            st_d.cnt = CNT_W'(MAG_W);
            st_d.bin = bin_i;
            st_d.bcd = '0;
        end else if (st_q.cnt != '0) begin
            for (int i = 0; i < NDIG; i++) begin
                if (adj[4*i +: 4] >= 4'd5) adj[4*i +: 4] = adj[4*i +: 4] + 4'd3;
            end
            cat      = {adj, st_q.bin} << 1;
            st_d.bcd = cat[BCD_W+MAG_W-1 -: BCD_W];
            st_d.bin = cat[MAG_W-1:0];
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.cnt != '0);
    assign last_o = (st_q.cnt == CNT_W'(1));
    assign bcd_o  = st_q.bcd;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        AST_DIGIT_DECIMAL: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.bcd[4*g +: 4] <= 4'd9); // R2
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !load_i) |=> (st_q.cnt == $past(st_q.cnt) - 1'b1)); // R1

endmodule

// File: rtl/bcd_store_unit.sv
module bcd_store_unit
    import bcdst_pkg::*;
#(
    parameter int NDIG = DIGITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [79:0]       src_i,
    input  logic              top_empty_i,
    input  logic [2:0]        top_ptr_i,
    input  logic [1:0]        rc_i,
    input  logic              inv_mask_i,
    output logic              done_o,
    output logic              wr_en_o,
    output logic [4*NDIG+7:0] bcd_o,
    output logic              inv_o,
    output logic              prec_o,
    output logic              stk_o,
    output logic              c1_o,
    output logic              pop_o,
    output logic [2:0]        free_reg_o,
    output logic [2:0]        pop_top_o
);

    localparam int MAG_W = nines_bits(NDIG);
    localparam int BCD_W = 4 * NDIG;
    localparam int OUT_W = BCD_W + 8;
    localparam logic [OUT_W-1:0] INDEF = {16'hFFFF, 2'b11, {(OUT_W-18){1'b0}}};

    typedef struct packed {
        logic       sign;
        logic       inv;
        logic       prec;
        logic       c1;
        logic       stk;
        logic       mask;
        logic [2:0] top;
        logic       done;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             r_sign, r_inv, r_prec, r_c1, r_stk;
    logic [MAG_W-1:0] r_mag;
    logic             busy, last, accept, commit;
    logic [BCD_W-1:0] digits;

    bcdst_round #(.NDIG(NDIG), .MAG_W(MAG_W)) i_round (
        .src_i   (src_i),
        .rc_i    (rc_i),
        .empty_i (top_empty_i),
        .sign_o  (r_sign),
        .mag_o   (r_mag),
        .inv_o   (r_inv),
        .prec_o  (r_prec),
        .c1_o    (r_c1),
        .stk_o   (r_stk)
    );

    assign accept = start_i && !busy;

    bcdst_dabble #(.NDIG(NDIG), .MAG_W(MAG_W)) i_dabble (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .bin_i  (r_mag),
        .busy_o (busy),
        .last_o (last),
        .bcd_o  (digits)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = last;
        if (accept) begin
            ctl_d.sign = r_sign;
            ctl_d.inv  = r_inv;
            ctl_d.prec = r_prec;
            ctl_d.c1   = r_c1;
            ctl_d.stk  = r_stk;
            ctl_d.mask = inv_mask_i;
            ctl_d.top  = top_ptr_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign commit     = ctl_q.done && (!ctl_q.inv || ctl_q.mask);
    assign done_o     = ctl_q.done;
    assign wr_en_o    = commit;
    assign pop_o      = commit;
    assign bcd_o      = ctl_q.inv ? INDEF : {ctl_q.sign, 7'b0, digits};
    assign inv_o      = ctl_q.inv;
    assign prec_o     = ctl_q.prec;
    assign stk_o      = ctl_q.stk;
    assign c1_o       = ctl_q.c1;
    assign free_reg_o = ctl_q.top;
    assign pop_top_o  = ctl_q.top + 3'd1;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R1
    AST_STORE_IN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> done_o); // R2
    AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && !inv_o) |-> (bcd_o[OUT_W-2 -: 7] == 7'd0)); // R2
    AST_INEXACT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        inv_o |-> !prec_o); // R4
    AST_C1_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        inv_o |-> !c1_o); // R5
    AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        stk_o |-> (inv_o && !c1_o)); // R8
    AST_INDEF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && inv_o) |-> (bcd_o == INDEF)); // R9
    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && inv_o && !ctl_q.mask) |-> (!wr_en_o && !pop_o)); // R10
    AST_POP_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> (pop_top_o == free_reg_o + 3'd1)); // R11

endmodule

// File: tb/test_bcd_store_unit.sv
`timescale 1ns/1ps
module test_bcd_store_unit;

    localparam int          LAT     = 60;
    localparam logic [63:0] MAXV    = 64'd999999999999999999;
    localparam logic [79:0] INDEF_C = 80'hFFFF_C000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [79:0] src_i = '0;
    logic        top_empty_i = 1'b0;
    logic [2:0]  top_ptr_i = '0;
    logic [1:0]  rc_i = '0;
    logic        inv_mask_i = 1'b1;
    logic        done_o, wr_en_o, inv_o, prec_o, stk_o, c1_o, pop_o;
    logic [79:0] bcd_o;
    logic [2:0]  free_reg_o, pop_top_o;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    bcd_store_unit i_bcd_store_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .src_i(src_i),
        .top_empty_i(top_empty_i), .top_ptr_i(top_ptr_i), .rc_i(rc_i),
        .inv_mask_i(inv_mask_i), .done_o(done_o), .wr_en_o(wr_en_o),
        .bcd_o(bcd_o), .inv_o(inv_o), .prec_o(prec_o), .stk_o(stk_o),
        .c1_o(c1_o), .pop_o(pop_o), .free_reg_o(free_reg_o), .pop_top_o(pop_top_o)
    );

    typedef struct packed {
        logic        inv;
        logic        prec;
        logic        c1;
        logic        stk;
        logic [79:0] word;
    } exp_t;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    function automatic logic [79:0] mk(input logic sgn, input logic [63:0] k, input int fb);
        int p;
        if (k == 0) return {sgn, 79'b0};
        p = 63;
        while (!k[p]) p--;
        return {sgn, 15'(16383 + p - fb), k << (63 - p)};
    endfunction

    // reference: integer part, fraction compared with one half
    function automatic exp_t model(input logic [79:0] s, input logic empty, input logic [1:0] rc);
        exp_t        r;
        logic        sg;
        logic [14:0] ex;
        logic [63:0] m, ip, fr, half, mag;
        int          e, cmp;
        logic        inexact, up;
        r  = '0;
        sg = s[79];
        ex = s[78:64];
        m  = s[63:0];
        if (empty) begin
            r.inv = 1'b1;
            r.stk = 1'b1;
            return r;
        end
        if (ex == 15'h7FFF || (ex != 0 && !m[63])) begin
            r.inv = 1'b1;
            return r;
        end
        e = int'(ex) - 16383;
        if (e >= 60) begin
            r.inv = 1'b1;
            return r;
        end
        if (e >= 0) begin
            ip   = m >> (63 - e);
            fr   = m - (ip << (63 - e));
            half = 64'd1 << (62 - e);
            cmp  = (fr > half) ? 1 : ((fr == half) ? 0 : -1);
            inexact = (fr != 0);
        end else if (e == -1) begin
            ip  = 0;
            cmp = (m > 64'h8000_0000_0000_0000) ? 1 : ((m == 64'h8000_0000_0000_0000) ? 0 : -1);
            inexact = (m != 0);
        end else begin
            ip  = 0;
            cmp = -1;
            inexact = (m != 0);
        end
        case (rc)
            2'd0:    up = inexact && (cmp > 0 || (cmp == 0 && ip[0]));
            2'd1:    up = sg && inexact;
            2'd2:    up = !sg && inexact;
            default: up = 1'b0;
        endcase
        mag = ip + (up ? 64'd1 : 64'd0);
        if (mag > MAXV) begin
            r.inv = 1'b1;
            return r;
        end
        r.prec = inexact;
        r.c1   = up;
        r.word = {sg, 79'b0};
        for (int i = 0; i < 18; i++) begin
            r.word[4*i +: 4] = 4'(mag % 10);
            mag = mag / 10;
        end
        return r;
    endfunction

    task automatic run_op(input string tag, input logic [79:0] s, input logic empty,
                          input logic [1:0] rc, input logic mask, input logic [2:0] top);
        exp_t x;
        int   n;
        bit   wr_exp;
        x = model(s, empty, rc);
        wr_exp = !x.inv || mask;
        @(negedge clk);
        start_i = 1'b1; src_i = s; top_empty_i = empty; rc_i = rc;
        inv_mask_i = mask; top_ptr_i = top;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done_o && n < LAT + 10);
        chk(n == LAT, "R1", {tag, " latency"}, 80'(n), 80'(LAT));
        chk(wr_en_o == wr_exp, x.inv ? (mask ? "R9" : "R10") : "R2", {tag, " store"},
            80'(wr_en_o), 80'(wr_exp));
        chk(pop_o == wr_exp, wr_exp ? "R11" : "R10", {tag, " pop"}, 80'(pop_o), 80'(wr_exp));
        chk(inv_o == x.inv, "R6/R7", {tag, " inv"}, 80'(inv_o), 80'(x.inv));
        chk(prec_o == x.prec, "R4", {tag, " prec"}, 80'(prec_o), 80'(x.prec));
        chk(c1_o == x.c1, "R5", {tag, " c1"}, 80'(c1_o), 80'(x.c1));
        chk(stk_o == x.stk, "R8", {tag, " stk"}, 80'(stk_o), 80'(x.stk));
        if (wr_exp) begin
            chk(bcd_o == (x.inv ? INDEF_C : x.word), x.inv ? "R9" : "R2", {tag, " word"},
                bcd_o, x.inv ? INDEF_C : x.word);
            chk(free_reg_o == top && pop_top_o == top + 3'd1, "R11", {tag, " top"},
                80'({free_reg_o, pop_top_o}), 80'({top, 3'(top + 3'd1)}));
        end
        @(negedge clk);
        chk(!done_o && !wr_en_o, "R1", {tag, " pulse"}, 80'({done_o, wr_en_o}), 80'd0);
    endtask

    initial begin
        #(4 * 150000);
        if (!ended) begin
            ended = 1'b1;
            errors++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [79:0] a;
        exp_t        xa;
        int          ndone, at;
        void'($urandom(32'd12358));
        repeat (3) @(negedge clk);
        chk(!done_o && !wr_en_o && !pop_o, "R1", "reset outputs",
            80'({done_o, wr_en_o, pop_o}), 80'd0);
        rst_n = 1'b1;

        run_op("R2 +0", mk(0, 0, 0), 0, 2'd0, 1, 3'd1);
        run_op("R2 -0", mk(1, 0, 0), 0, 2'd0, 1, 3'd2);
        run_op("R3 1.5 nearest", mk(0, 3, 1), 0, 2'd0, 1, 3'd0);
        run_op("R3 2.5 nearest", mk(0, 5, 1), 0, 2'd0, 1, 3'd0);
        run_op("R3 -2.5 down", mk(1, 5, 1), 0, 2'd1, 1, 3'd0);
        run_op("R3 -2.5 up", mk(1, 5, 1), 0, 2'd2, 1, 3'd0);
        run_op("R3 2.75 zero", mk(0, 11, 2), 0, 2'd3, 1, 3'd0);
        run_op("R4 exact", mk(0, 64'd123456789, 0), 0, 2'd0, 1, 3'd3);
        run_op("R5 0.25 up", mk(0, 1, 2), 0, 2'd2, 1, 3'd3);
        run_op("R6 max", mk(1, MAXV, 0), 0, 2'd0, 1, 3'd4);
        run_op("R6 max+0.5", mk(0, 2 * MAXV + 1, 1), 0, 2'd0, 1, 3'd4);
        run_op("R6 2^60", mk(0, 64'd1 << 60, 0), 0, 2'd3, 1, 3'd4);
        run_op("R7 inf", {1'b1, 15'h7FFF, 64'h8000_0000_0000_0000}, 0, 2'd0, 1, 3'd5);
        run_op("R7 nan", {1'b0, 15'h7FFF, 64'hC000_0000_0000_0001}, 0, 2'd0, 1, 3'd5);
        run_op("R7 unnormal", {1'b0, 15'd16390, 64'h4000_0000_0000_0000}, 0, 2'd0, 1, 3'd5);
        run_op("R8 empty", mk(0, 7, 0), 1, 2'd2, 1, 3'd6);
        run_op("R10 unmasked", {1'b0, 15'h7FFF, 64'h8000_0000_0000_0000}, 0, 2'd0, 0, 3'd6);
        run_op("R10 unmasked empty", mk(0, 7, 0), 1, 2'd0, 0, 3'd6);
        run_op("R11 wrap", mk(0, 42, 0), 0, 2'd0, 1, 3'd7);

        // R1: a second request during a conversion is ignored
        a  = mk(0, 64'd987654321, 0);
        xa = model(a, 1'b0, 2'd0);
        @(negedge clk);
        start_i = 1'b1; src_i = a; top_empty_i = 0; rc_i = 0; inv_mask_i = 1;
        @(negedge clk);
        start_i = 1'b0;
        ndone = 0; at = 0;
        for (int i = 1; i <= 140; i++) begin
            if (i == 10) begin
                start_i = 1'b1;
                src_i   = mk(0, 64'd5, 0);
            end
            if (i == 11) start_i = 1'b0;
            @(negedge clk);
            if (done_o) begin
                ndone++;
                at = i;
                chk(bcd_o == xa.word, "R1", "busy start word", bcd_o, xa.word);
            end
        end
        chk(ndone == 1 && at == LAT, "R1", "busy start ignored",
            80'({ndone[15:0], at[15:0]}), 80'({16'd1, 16'(LAT)}));

        for (int t = 0; t < 200; t++) begin
            logic [63:0] m;
            logic [14:0] ex;
            m = {1'b1, 31'($urandom), 32'($urandom)};
            if ($urandom_range(0, 3) == 0) m[31:0] = '0;
            ex = 15'(16383 + int'($urandom_range(0, 64)) - 3);
            run_op("rand", {1'($urandom), ex, m}, ($urandom_range(0, 15) == 0),
                   2'($urandom), ($urandom_range(0, 3) != 0), 3'($urandom));
        end

        if (!ended) begin
            ended = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule